// File: doc/BRIEF.md
# Software Interrupt Pending Register with Level Masking

This block holds one thread's software interrupt request bits and turns them into a vector of pending interrupt lines. Software changes the register through one write port. A two-bit alias select on that port chooses how the written word is applied: it can replace the register, OR bits into it, or clear the bits that are written as ones. Two strobes from the timer-compare logic raise the tick-match bit (bit 0) and the system-tick-match bit (bit 16) directly.

A separate port loads the 4-bit processor interrupt level. The pending vector is evaluated again every time the register or the level changes. Bits 1 to 15 are masked by their own index: a bit is pending only when its index is above the level. The two timer bits at the ends of the register follow a different rule. They are pending while the level is below 14. Downstream trap logic reads the pending vector. Software reads the register value on a 64-bit read bus.

Top module: `soft_irq_unit`

## Requirements
- R1: After reset, and after a reset asserted mid-run, the register, the interrupt level and the pending vector are all zero.
- R2: A write with `wrSel` = 0 (direct) replaces register bits 16..0 with `wrData[16:0]`.
- R3: A write with `wrSel` = 1 (set alias) ORs `wrData[16:0]` into the register.
- R4: A write with `wrSel` = 2 (clear alias) clears every register bit whose `wrData` bit is one and leaves the other bits unchanged.
- R5: A write with `wrSel` = 3 changes neither `rdData` nor `pendVec`.
- R6: `lvlWrEn` loads `lvlWrData` as the 4-bit interrupt level, and the pending vector is evaluated again against the new level even when the register does not change.
- R7: For each bit index i from 1 to 15, `pendVec[i]` is 1 only when register bit i is 1 and i is strictly greater than the level.
- R8: `pendVec[0]` and `pendVec[16]` are 1 only when the matching register bit is 1 and the level is below 14.
- R9: `tmrSet[0]` sets register bit 0 and `tmrSet[1]` sets register bit 16. When a timer strobe arrives in the same cycle as a software write of any alias, the strobe is applied after the alias, so the bit ends up set and the rest of the software update still takes effect.
- R10: A write or level load becomes visible on `rdData` and `pendVec` at the first rising clock edge after it is presented, not before, and `pendVec` always matches the register value and level shown in that same cycle.
- R11: `rdData` bits 63..17 always read zero, and `wrData` bits above 16 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Alias: 0 direct, 1 set, 2 clear, 3 reserved |
| wrData | input | 64 | Write data |
| lvlWrEn | input | 1 | Interrupt level load strobe |
| lvlWrData | input | 4 | New interrupt level |
| tmrSet | input | 2 | Timer match strobes: bit 0 sets reg bit 0, bit 1 sets reg bit 16 |
| rdData | output | 64 | Register value, zero extended |
| pendVec | output | 17 | Registered pending interrupt lines |

## Verification
The checker evaluates properties on every cycle. It checks the one-cycle effect of each alias when no timer strobe is present, and it checks that a reserved-alias write leaves both outputs stable. It also confirms that a timer strobe always leaves its bit set, that the upper read bits stay zero, and that no pending line is ever raised without its register bit. A shadow copy of the level lets it check, line by line, that no pending line is raised outside its level rule. Some behaviours can only be shown by the bench's scenarios:
- that a line really does go pending when it should;
- how a clear merges with a same-cycle timer strobe;
- that nothing changes before the clock edge;
- that a reset asserted mid-run restores the level to zero.

// File: rtl/soft_irq_pkg.sv
package soft_irq_pkg;

  typedef enum logic [1:0] {
    WR_DIRECT = 2'd0,
    WR_SET    = 2'd1,
    WR_CLEAR  = 2'd2,
    WR_RSVD   = 2'd3
  } wr_sel_e;

  // Strobes from control to datapath, at most one software alias active
  typedef struct packed {
    logic ldDirect;
    logic orSet;
    logic andClr;
    logic ldLvl;
    logic tickHit;
    logic stickHit;
  } strobe_t;

endpackage

// File: rtl/soft_irq_ctl.sv
module soft_irq_ctl
  import soft_irq_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       lvlWrEn,
  input  logic [1:0] tmrSet,
  output strobe_t    strb
);

  wr_sel_e selCode;

  assign selCode = wr_sel_e'(wrSel);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (selCode)
        WR_DIRECT: strb.ldDirect = 1'b1;
        WR_SET:    strb.orSet    = 1'b1;
        WR_CLEAR:  strb.andClr   = 1'b1;
        default:   ;
      endcase
    end
    strb.ldLvl    = lvlWrEn;
    strb.tickHit  = tmrSet[0];
    strb.stickHit = tmrSet[1];
  end

endmodule

// File: rtl/soft_irq_mask.sv
module soft_irq_mask #(
  parameter int LINES     = 17,
  parameter int LVL_W     = 4,
  parameter int HI_THRESH = 14
) (
  input  logic [LINES-1:0] reqBits,
  input  logic [LVL_W-1:0] lvl,
  output logic [LINES-1:0] pend
);

  localparam int TOP_BIT = LINES - 1;

  logic [31:0] lvlExt;
  logic        belowHi;

  assign lvlExt  = 32'(lvl);
  assign belowHi = (lvlExt < 32'(HI_THRESH));

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i == 0 || i == TOP_BIT) begin : g_edge
      assign pend[i] = reqBits[i] & belowHi;
    end else begin : g_mid
      assign pend[i] = reqBits[i] & (lvlExt < 32'(i));
    end
  end

endmodule

// File: rtl/soft_irq_dp.sv
module soft_irq_dp
  import soft_irq_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int LINES     = 17,
  parameter int LVL_W     = 4,
  parameter int HI_THRESH = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [LINES-1:0]  wrLow,
  input  logic [LVL_W-1:0]  lvlWrData,
  output logic [DATA_W-1:0] rdData,
  output logic [LINES-1:0]  pendVec
);

  localparam int TOP_BIT = LINES - 1;

  logic [LINES-1:0] regQ, swNext, tmrMask, regNext, pendNext;
  logic [LVL_W-1:0] lvlQ, lvlNext;

  always_comb begin
    if (strb.ldDirect)      swNext = wrLow;
    else if (strb.orSet)    swNext = regQ | wrLow;
    else if (strb.andClr)   swNext = regQ & ~wrLow;
    else                    swNext = regQ;
  end

  always_comb begin
    tmrMask          = '0;
    tmrMask[0]       = strb.tickHit;
    tmrMask[TOP_BIT] = strb.stickHit;
  end

  // timer strobes win over a same-cycle clear
  assign regNext = swNext | tmrMask;
  assign lvlNext = strb.ldLvl ? lvlWrData : lvlQ;

  soft_irq_mask #(
    .LINES(LINES), .LVL_W(LVL_W), .HI_THRESH(HI_THRESH)
  ) u_mask (
    .reqBits(regNext),
    .lvl    (lvlNext),
    .pend   (pendNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ    <= '0;
      lvlQ    <= '0;
      pendVec <= '0;
    end else begin
      regQ    <= regNext;
      lvlQ    <= lvlNext;
      pendVec <= pendNext;
    end
  end

  assign rdData = {{(DATA_W-LINES){1'b0}}, regQ};

endmodule

// File: rtl/soft_irq_unit.sv
module soft_irq_unit
  import soft_irq_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int LINES     = 17,
  parameter int LVL_W     = 4,
  parameter int HI_THRESH = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lvlWrEn,
  input  logic [LVL_W-1:0]  lvlWrData,
  input  logic [1:0]        tmrSet,
  output logic [DATA_W-1:0] rdData,
  output logic [LINES-1:0]  pendVec
);

  strobe_t strb;
  logic    wrDataUnused;

  assign wrDataUnused = ^wrData[DATA_W-1:LINES];

  soft_irq_ctl u_ctl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .lvlWrEn(lvlWrEn),
    .tmrSet (tmrSet),
    .strb   (strb)
  );

  soft_irq_dp #(
    .DATA_W(DATA_W), .LINES(LINES), .LVL_W(LVL_W), .HI_THRESH(HI_THRESH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrLow    (wrData[LINES-1:0]),
    .lvlWrData(lvlWrData),
    .rdData   (rdData),
    .pendVec  (pendVec)
  );

endmodule

// File: rtl/soft_irq_unit_chk.sv
module soft_irq_unit_chk #(
  parameter int DATA_W    = 64,
  parameter int LINES     = 17,
  parameter int LVL_W     = 4,
  parameter int HI_THRESH = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic              lvlWrEn,
  input logic [LVL_W-1:0]  lvlWrData,
  input logic [1:0]        tmrSet,
  input logic [DATA_W-1:0] rdData,
  input logic [LINES-1:0]  pendVec
);

  localparam int TOP_BIT = LINES - 1;

  logic [LVL_W-1:0] shLvl;
  logic [LINES-1:0] rdLow, wrLow;
  logic             chkUnused;

  assign rdLow     = rdData[LINES-1:0];
  assign wrLow     = wrData[LINES-1:0];
  assign chkUnused = ^wrData[DATA_W-1:LINES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        shLvl <= '0;
    else if (lvlWrEn) shLvl <= lvlWrData;
  end

  p_direct_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0 && tmrSet == 2'b00) |=> rdLow == $past(wrLow));

  p_set_or_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd1 && tmrSet == 2'b00) |=> rdLow == ($past(rdLow) | $past(wrLow)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd2 && tmrSet == 2'b00) |=> rdLow == ($past(rdLow) & ~$past(wrLow)));

  p_rsvd_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd3 && !lvlWrEn && tmrSet == 2'b00) |=> ($stable(rdData) && $stable(pendVec)));

  p_tick_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    tmrSet[0] |=> rdData[0]);

  p_stick_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    tmrSet[1] |=> rdData[TOP_BIT]);

  p_pend_has_bit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & ~rdLow) == '0);

  p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:LINES] == '0);

  p_edge_lo_r8: assert property (@(posedge clk) disable iff (!rstN)
    pendVec[0] |-> (32'(shLvl) < 32'(HI_THRESH)));

  p_edge_hi_r8: assert property (@(posedge clk) disable iff (!rstN)
    pendVec[TOP_BIT] |-> (32'(shLvl) < 32'(HI_THRESH)));

  for (genvar i = 1; i < TOP_BIT; i++) begin : g_mid
    p_mid_level_r7: assert property (@(posedge clk) disable iff (!rstN)
      pendVec[i] |-> (32'(shLvl) < 32'(i)));
  end

endmodule

bind soft_irq_unit soft_irq_unit_chk #(
  .DATA_W(DATA_W), .LINES(LINES), .LVL_W(LVL_W), .HI_THRESH(HI_THRESH)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .lvlWrEn(lvlWrEn), .lvlWrData(lvlWrData), .tmrSet(tmrSet),
  .rdData(rdData), .pendVec(pendVec)
);

// File: tb/soft_irq_unit_tb.sv
module soft_irq_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic        we;
    logic [1:0]  sel;
    logic [16:0] data;
    logic        le;
    logic [3:0]  lvl;
    logic [1:0]  tmr;
    logic [16:0] expReg;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, 17'h1FFFF, 1'b0, 4'd0,  2'b00, 17'h1FFFF}, // R2 direct
    '{1'b0, 2'd0, 17'h00000, 1'b1, 4'd5,  2'b00, 17'h1FFFF}, // R6 level 5
    '{1'b1, 2'd2, 17'h000F0, 1'b0, 4'd0,  2'b00, 17'h1FF0F}, // R4 clear
    '{1'b1, 2'd1, 17'h00030, 1'b0, 4'd0,  2'b00, 17'h1FF3F}, // R3 set
    '{1'b0, 2'd0, 17'h00000, 1'b1, 4'd14, 2'b00, 17'h1FF3F}, // R8 level 14
    '{1'b1, 2'd3, 17'h1FFFF, 1'b0, 4'd0,  2'b00, 17'h1FF3F}, // R5 reserved
    '{1'b1, 2'd0, 17'h00000, 1'b0, 4'd0,  2'b01, 17'h00001}, // R9 direct+tick
    '{1'b1, 2'd2, 17'h1FFFF, 1'b0, 4'd0,  2'b10, 17'h10000}, // R9 clear+stick
    '{1'b0, 2'd0, 17'h00000, 1'b1, 4'd13, 2'b00, 17'h10000}, // R8 level 13
    '{1'b1, 2'd1, 17'h08002, 1'b1, 4'd15, 2'b00, 17'h18002}, // R7 level 15
    '{1'b1, 2'd0, 17'h04000, 1'b1, 4'd0,  2'b11, 17'h14001}, // R9 both timers
    '{1'b1, 2'd1, 17'h00000, 1'b0, 4'd0,  2'b00, 17'h14001}, // R3 set zero
    '{1'b0, 2'd0, 17'h00000, 1'b0, 4'd0,  2'b00, 17'h14001}, // idle
    '{1'b1, 2'd2, 17'h10001, 1'b0, 4'd0,  2'b00, 17'h04000}  // R4 clear ends
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [63:0] wrData = '0;
  logic        lvlWrEn = 1'b0;
  logic [3:0]  lvlWrData = '0;
  logic [1:0]  tmrSet = 2'b00;
  logic [63:0] rdData;
  logic [16:0] pendVec;

  int nChecks = 0;
  int nFails  = 0;
  logic [3:0] mLvl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_irq_unit u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .lvlWrEn(lvlWrEn), .lvlWrData(lvlWrData), .tmrSet(tmrSet),
    .rdData(rdData), .pendVec(pendVec)
  );

  function automatic logic [16:0] modelPend(logic [16:0] r, logic [3:0] l);
    logic [16:0] p;
    for (int i = 0; i < 17; i++) begin
      if (i == 0 || i == 16) p[i] = r[i] && (l < 4'd14);
      else                   p[i] = r[i] && (i > int'(l));
    end
    return p;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic we, logic [1:0] sel, logic [63:0] d,
                       logic le, logic [3:0] l, logic [1:0] t);
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = d; lvlWrEn = le; lvlWrData = l; tmrSet = t;
    if (le) mLvl = l;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 2'd0; wrData = '0; lvlWrEn = 1'b0; lvlWrData = '0; tmrSet = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rdData", rdData, 64'h0);
    check("R1 reset pendVec", {47'h0, pendVec}, 64'h0);
    rstN = 1'b1;

    // R10: nothing visible before the edge
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'd0; wrData = 64'h0_0000_0000_0000_0004;
    #(CLK_PERIOD/4);
    check("R10 before edge", rdData, 64'h0);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    check("R10 after edge rd", rdData, 64'h4);
    check("R10 after edge pend", {47'h0, pendVec}, 64'h4);

    for (int k = 0; k < NVEC; k++) begin
      apply(VECS[k].we, VECS[k].sel, {47'h0, VECS[k].data},
            VECS[k].le, VECS[k].lvl, VECS[k].tmr);
      check($sformatf("R2-R9 vec%0d reg", k), rdData, {47'h0, VECS[k].expReg});
      check($sformatf("R7/R8 vec%0d pend", k), {47'h0, pendVec},
            {47'h0, modelPend(VECS[k].expReg, mLvl)});
    end

    // R11: wide write, upper bits dropped
    apply(1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd0, 2'b00);
    check("R11 upper zero", rdData, 64'h1FFFF);
    check("R8 pend level0", {47'h0, pendVec}, 64'h1FFFF);

    // R6: level-only write re-masks
    apply(1'b0, 2'd0, 64'h0, 1'b1, 4'd3, 2'b00);
    check("R6 level 3 pend", {47'h0, pendVec}, 64'h1FFF1);

    // R9: timer strobe with no software write
    apply(1'b1, 2'd0, 64'h0, 1'b0, 4'd0, 2'b00);
    apply(1'b0, 2'd0, 64'h0, 1'b0, 4'd0, 2'b10);
    check("R9 stick alone", rdData, 64'h10000);

    // R1: mid-run reset clears register and level
    @(negedge clk);
    rstN = 1'b0;
    #(CLK_PERIOD/4);
    check("R1 midrun rd", rdData, 64'h0);
    check("R1 midrun pend", {47'h0, pendVec}, 64'h0);
    @(negedge clk);
    rstN = 1'b1;
    mLvl = '0;
    apply(1'b1, 2'd0, 64'h2, 1'b0, 4'd0, 2'b00);
    check("R1 level back to zero", {47'h0, pendVec}, 64'h2);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule